// File: doc/BRIEF.md
# Shared-Low-Bit Column Counter Bank

This block is the digital counting stage behind a row of single-slope column converters. Instead of giving every column a full-width counter, one fast low-order counter is built once and its value is broadcast to every column of the group, together with a one-cycle wrap pulse. Each column holds only the high-order part of the code. That part advances on each wrap pulse. Because the fast-toggling bits exist only once, the count clock drives a small load, and it can run at a much higher rate than a clock that has to reach a full counter in every column.

A conversion begins with a start pulse. On the first rising edge at which a column's comparator input is seen high, that column stops its high-order counter and latches the broadcast low-order value. The two parts together form the column's code, which is the number of count cycles that elapsed before the trip. A column that never trips before the last count value reports the all-ones code and raises its saturation flag. The results stay on the read-out bus until the next start pulse. The low-order value can be broadcast in Gray code, so a column that samples it at an arbitrary moment never latches a mix of two adjacent values.

Top module: `hcc_bank`

## Requirements
- R1: While reset is low and after it is released, every column code is 0, every saturation flag is 0, and busy and done are both 0.
- R2: On the rising edge that samples conv_start high, all column counters, the shared counter, all latched values and all flags are cleared. From the next cycle, busy is 1, done is 0 and every code reads 0.
- R3: Number the rising edges after the start edge k = 0, 1, 2, and so on. A column whose comparator is sampled high on edge k reports code k. Codes read 0 until the column trips.
- R4: Bits [LSB_W-1:0] of a code come from the single shared counter. The upper MSB_W bits are the column's own count of wraps of that counter. For example, with LSB_W = 5, trips on edges 31 and 32 report 31 and 32.
- R5: Once a column has tripped, later changes of its comparator input during the same conversion do not change its code.
- R6: A column that has not tripped by edge 2^(LSB_W+MSB_W)-1 reports the all-ones code and sets its saturation flag. A column that trips exactly on that edge reports all-ones with its saturation flag clear.
- R7: After edge 2^(LSB_W+MSB_W)-1, busy falls and done rises. Codes and flags then hold until the next start. Busy and done are never both 1.
- R8: A start pulse while a conversion is running discards all results and begins a new conversion from count 0.
- R9: Comparator inputs have no effect while no conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Fast count clock |
| rst_n | input | 1 | Active-low reset |
| conv_start | input | 1 | Start-of-conversion pulse |
| cmp_in | input | N_COLS | Comparator output of each column |
| col_code | output | N_COLS*CODE_W | Conversion codes; column c occupies [c*CODE_W +: CODE_W] |
| col_sat | output | N_COLS | Saturation flag of each column |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | Conversion finished; results valid |

## Verification
A wrong shared count or a lost wrap pulse changes the code of the next column that trips. The error can therefore be seen within a single conversion. Trips placed on either side of a wrap boundary expose a carry fault by exactly 2^LSB_W, as soon as those columns latch. A wrong end-of-count state shows up as busy or done switching in the wrong cycle, or as a wrong saturation flag, within one count period. A column that fails to freeze shows up as a code that moves after its trip, and the bench compares every code against its model on every clock.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
   // Encoding used on the shared low-order broadcast bus.
   typedef enum logic [0:0] {
      BC_BIN  = 1'b0,
      BC_GRAY = 1'b1
   } bcast_e;
endpackage

// File: rtl/hcc_lsb_gen.sv
module hcc_lsb_gen
   import hcc_pkg::*;
#(
   parameter int     LSB_W = 5,
   parameter bcast_e ENC   = BC_GRAY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   output logic [LSB_W-1:0] lo_bus,
   output logic             wrap
);
   localparam logic [LSB_W-1:0] ONE_LO = LSB_W'(1);

   logic [LSB_W-1:0] bin_q;
   logic [LSB_W-1:0] bin_nxt;

   always_comb begin
      bin_nxt = bin_q;
      if (clr)      bin_nxt = '0;
      else if (run) bin_nxt = bin_q + ONE_LO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bin_q <= '0;
      else        bin_q <= bin_nxt;
   end

   // Wrap pulse accompanies the broadcast value that precedes roll-over.
   assign wrap = run && (bin_q == '1);

   generate
      if (ENC == BC_GRAY) begin : g_gray
         logic [LSB_W-1:0] gray_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gray_q <= '0;
            else        gray_q <= bin_nxt ^ (bin_nxt >> 1);
         end
         assign lo_bus = gray_q;
      end else begin : g_bin
         assign lo_bus = bin_q;
      end
   endgenerate
endmodule

// File: rtl/hcc_seq.sv
module hcc_seq #(
   parameter int MSB_W = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic wrap,
   output logic busy,
   output logic done,
   output logic last
);
   localparam logic [MSB_W-1:0] ONE_HI = MSB_W'(1);

   logic [MSB_W-1:0] epoch_q;

   assign last = busy && wrap && (epoch_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         epoch_q <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         done    <= 1'b0;
         epoch_q <= '0;
      end else if (last) begin
         busy    <= 1'b0;
         done    <= 1'b1;
      end else if (busy && wrap) begin
         epoch_q <= epoch_q + ONE_HI;
      end
   end
endmodule

// File: rtl/hcc_col.sv
module hcc_col
   import hcc_pkg::*;
#(
   parameter int     LSB_W = 5,
   parameter int     MSB_W = 10,
   parameter bcast_e ENC   = BC_GRAY,
   localparam int    CODE_W = LSB_W + MSB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic              last,
   input  logic              wrap,
   input  logic [LSB_W-1:0]  lo_bus,
   input  logic              cmp,
   output logic [CODE_W-1:0] code,
   output logic              sat
);
   localparam logic [MSB_W-1:0] ONE_HI = MSB_W'(1);

   logic [MSB_W-1:0] hi_q;
   logic [LSB_W-1:0] cap_q;
   logic [LSB_W-1:0] cap_bin;
   logic             frz_q;
   logic             sat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         cap_q <= '0;
         frz_q <= 1'b0;
         sat_q <= 1'b0;
      end else if (clr) begin
         hi_q  <= '0;
         cap_q <= '0;
         frz_q <= 1'b0;
         sat_q <= 1'b0;
      end else if (run && !frz_q && !sat_q) begin
         if (cmp) begin
            frz_q <= 1'b1;
            cap_q <= lo_bus;
         end else if (last) begin
            sat_q <= 1'b1;
         end else if (wrap) begin
            hi_q  <= hi_q + ONE_HI;
         end
      end
   end

   generate
      if (ENC == BC_GRAY) begin : g_dec
         always_comb begin
            for (int i = 0; i < LSB_W; i++) cap_bin[i] = ^(cap_q >> i);
         end
      end else begin : g_pass
         assign cap_bin = cap_q;
      end
   endgenerate

   always_comb begin
      if (sat_q)      code = '1;
      else if (frz_q) code = {hi_q, cap_bin};
      else            code = '0;
   end
   assign sat = sat_q;
endmodule

// File: rtl/hcc_bank.sv
module hcc_bank
   import hcc_pkg::*;
#(
   parameter int     N_COLS = 64,
   parameter int     LSB_W  = 5,
   parameter int     MSB_W  = 10,
   parameter bcast_e ENC    = BC_GRAY,
   localparam int    CODE_W = LSB_W + MSB_W
) (
   input  logic                     clk_cnt,
   input  logic                     rst_n,
   input  logic                     conv_start,
   input  logic [N_COLS-1:0]        cmp_in,
   output logic [N_COLS*CODE_W-1:0] col_code,
   output logic [N_COLS-1:0]        col_sat,
   output logic                     conv_busy,
   output logic                     conv_done
);
   generate
      if (N_COLS < 1)   begin : g_bad_cols $error("N_COLS must be at least 1"); end
      if (LSB_W < 1)    begin : g_bad_lsb  $error("LSB_W must be at least 1"); end
      if (MSB_W < 1)    begin : g_bad_msb  $error("MSB_W must be at least 1"); end
      if (CODE_W > 30)  begin : g_bad_code $error("LSB_W+MSB_W must not exceed 30"); end
   endgenerate

   logic [LSB_W-1:0] lo_bus;
   logic             wrap;
   logic             last;

   hcc_lsb_gen #(.LSB_W(LSB_W), .ENC(ENC)) lsb_i (
      .clk    (clk_cnt),
      .rst_n  (rst_n),
      .clr    (conv_start),
      .run    (conv_busy),
      .lo_bus (lo_bus),
      .wrap   (wrap)
   );

   hcc_seq #(.MSB_W(MSB_W)) seq_i (
      .clk   (clk_cnt),
      .rst_n (rst_n),
      .start (conv_start),
      .wrap  (wrap),
      .busy  (conv_busy),
      .done  (conv_done),
      .last  (last)
   );

   generate
      for (genvar c = 0; c < N_COLS; c++) begin : g_col
         hcc_col #(.LSB_W(LSB_W), .MSB_W(MSB_W), .ENC(ENC)) col_i (
            .clk    (clk_cnt),
            .rst_n  (rst_n),
            .clr    (conv_start),
            .run    (conv_busy),
            .last   (last),
            .wrap   (wrap),
            .lo_bus (lo_bus),
            .cmp    (cmp_in[c]),
            .code   (col_code[c*CODE_W +: CODE_W]),
            .sat    (col_sat[c])
         );
      end
   endgenerate
endmodule

// File: rtl/hcc_bank_chk.sv
module hcc_bank_chk #(
   parameter int N_COLS = 64,
   parameter int CODE_W = 15
) (
   input logic                     clk_cnt,
   input logic                     rst_n,
   input logic                     conv_start,
   input logic [N_COLS*CODE_W-1:0] col_code,
   input logic [N_COLS-1:0]        col_sat,
   input logic                     conv_busy,
   input logic                     conv_done
);
   p_busy_done_excl_r7: assert property (@(posedge clk_cnt) disable iff (!rst_n)
      !(conv_busy && conv_done));

   p_start_clears_r2: assert property (@(posedge clk_cnt) disable iff (!rst_n)
      conv_start |=> (conv_busy && !conv_done && col_code == '0 && col_sat == '0));

   p_idle_hold_r9: assert property (@(posedge clk_cnt) disable iff (!rst_n)
      (conv_done && !conv_start) |=> ($stable(col_code) && $stable(col_sat)));

   generate
      for (genvar c = 0; c < N_COLS; c++) begin : g_c
         p_sat_all_ones_r6: assert property (@(posedge clk_cnt) disable iff (!rst_n)
            col_sat[c] |-> (col_code[c*CODE_W +: CODE_W] == '1));

         p_frozen_code_r5: assert property (@(posedge clk_cnt) disable iff (!rst_n)
            (conv_busy && !conv_start && col_code[c*CODE_W +: CODE_W] != '0)
               |=> $stable(col_code[c*CODE_W +: CODE_W]));
      end
   endgenerate
endmodule

bind hcc_bank hcc_bank_chk #(.N_COLS(N_COLS), .CODE_W(CODE_W)) chk_i (
   .clk_cnt    (clk_cnt),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .col_code   (col_code),
   .col_sat    (col_sat),
   .conv_busy  (conv_busy),
   .conv_done  (conv_done)
);

// File: tb/hcc_bank_tb_top.sv
module hcc_bank_tb_top;
   localparam int N    = 4;
   localparam int LW   = 5;
   localparam int MW   = 4;
   localparam int CW   = LW + MW;
   localparam int MAXV = (1 << CW) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_r = 1'b0;
   logic [N-1:0]    cmp_r = '0;
   logic [N*CW-1:0] col_code;
   logic [N-1:0]    col_sat;
   logic            busy, done;

   always #2 clk = ~clk;

   hcc_bank #(.N_COLS(N), .LSB_W(LW), .MSB_W(MW)) dut_i (
      .clk_cnt(clk), .rst_n(rst_n), .conv_start(start_r), .cmp_in(cmp_r),
      .col_code(col_code), .col_sat(col_sat), .conv_busy(busy), .conv_done(done)
   );

   int total = 0, bad = 0, cycles = 0;
   int trip [N];
   bit idle_cmp = 1'b0;
   bit cmp_on = 1'b0;

   // behavioural reference model
   int m_v;
   bit m_busy, m_done;
   int m_code [N];
   bit m_frz [N], m_sat [N];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_v = 0; m_busy = 0; m_done = 0;
         for (int c = 0; c < N; c++) begin m_code[c] = 0; m_frz[c] = 0; m_sat[c] = 0; end
      end else if (start_r) begin
         m_v = 0; m_busy = 1; m_done = 0;
         for (int c = 0; c < N; c++) begin m_code[c] = 0; m_frz[c] = 0; m_sat[c] = 0; end
      end else if (m_busy) begin
         for (int c = 0; c < N; c++) begin
            if (!m_frz[c] && !m_sat[c]) begin
               if (cmp_r[c]) begin m_frz[c] = 1; m_code[c] = m_v; end
               else if (m_v == MAXV) begin m_sat[c] = 1; m_code[c] = MAXV; end
            end
         end
         if (m_v == MAXV) begin m_busy = 0; m_done = 1; end
         else m_v++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int code_of(input int c);
      return int'(col_code[c*CW +: CW]);
   endfunction

   task automatic compare();
      for (int c = 0; c < N; c++) begin
         chk(code_of(c) == m_code[c], "R3 code", code_of(c), m_code[c]);
         chk(col_sat[c] == m_sat[c], "R6 sat", int'(col_sat[c]), int'(m_sat[c]));
      end
      chk(busy == m_busy, "R7 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R7 done", int'(done), int'(m_done));
   endtask

   task automatic drive_cmp();
      for (int c = 0; c < N; c++) begin
         if (!m_busy)          cmp_r[c] = idle_cmp;
         else if (!cmp_on)     cmp_r[c] = 1'b0;
         else if (trip[c] < 0) cmp_r[c] = 1'b0;
         else if (m_v < trip[c]) cmp_r[c] = 1'b0;
         else                  cmp_r[c] = ((m_v - trip[c]) % 3) != 1;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      start_r = 1'b0;
      drive_cmp();
   endtask

   task automatic pulse_start(input int t0, input int t1, input int t2, input int t3);
      @(negedge clk);
      compare();
      trip[0] = t0; trip[1] = t1; trip[2] = t2; trip[3] = t3;
      start_r = 1'b1;
      cmp_r   = '0;
      cmp_on  = 1'b1;
      tick();
      // R2: one cycle after the start edge
      chk(busy && !done, "R2 busy after start", int'(busy), 1);
      chk(col_code == '0 && col_sat == '0, "R2 cleared", int'(col_sat), 0);
   endtask

   task automatic run_to_end();
      while (m_busy) tick();
      tick();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < N; c++) trip[c] = -1;
      repeat (4) @(negedge clk);
      // R1 during reset
      chk(col_code == '0 && col_sat == '0 && !busy && !done, "R1 reset", int'(busy), 0);
      rst_n = 1'b1;
      repeat (3) tick();
      chk(col_code == '0 && !busy && !done, "R1 after release", int'(done), 0);

      // conversion A: first edge, wrap boundary, never
      pulse_start(0, 31, 32, -1);
      run_to_end();
      chk(code_of(0) == 0,  "R3 trip on first edge", code_of(0), 0);
      chk(code_of(1) == 31, "R4 below wrap", code_of(1), 31);
      chk(code_of(2) == 32, "R4 after wrap", code_of(2), 32);
      chk(code_of(3) == MAXV && col_sat[3], "R6 saturated", code_of(3), MAXV);
      chk(done && !busy, "R7 done level", int'(done), 1);

      // conversion B: last edge, early trip with later toggles
      pulse_start(MAXV, 1, 100, 300);
      run_to_end();
      chk(code_of(0) == MAXV && !col_sat[0], "R6 trip on last edge", int'(col_sat[0]), 0);
      chk(code_of(1) == 1, "R5 later toggles ignored", code_of(1), 1);
      chk(code_of(3) == 300, "R3 mid count", code_of(3), 300);

      // conversion C: restart mid-run
      pulse_start(50, -1, -1, 250);
      while (m_v < 200) tick();
      chk(code_of(0) == 50, "R3 before restart", code_of(0), 50);
      pulse_start(5, 480, -1, 63);
      run_to_end();
      chk(code_of(0) == 5,   "R8 restart result", code_of(0), 5);
      chk(code_of(1) == 480, "R8 restart result", code_of(1), 480);
      chk(code_of(3) == 63,  "R4 wrap boundary", code_of(3), 63);

      // conversion D: nothing trips
      pulse_start(-1, -1, -1, -1);
      run_to_end();
      chk(col_sat == '1, "R6 all saturated", int'(col_sat), (1 << N) - 1);

      // R9: comparators high while idle
      idle_cmp = 1'b1;
      repeat (20) tick();
      chk(col_sat == '1 && code_of(2) == MAXV && done, "R9 idle cmp ignored", code_of(2), MAXV);
      idle_cmp = 1'b0;
      tick();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule